// File: doc/BRIEF.md
# Global-History XOR Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. The table index for a branch is a field of its address XORed with a global history register. That register holds the resolved outcomes of the most recent branches, the newest in the least significant bit. A counter therefore learns the usual outcome of one branch under one recent-history pattern, not of the branch alone.

The fetch side presents the address field on the predict port. In the same cycle it receives the direction and a snapshot of the history that formed the index. When the branch resolves, the back end returns the same address field, the outcome and that snapshot on the update port. The update then reaches the entry that was read at predict time, even if other branches have since moved the history. At the next clock edge the counter moves and the resolved outcome is shifted into the history.

Top module: `hist_xor_dir_pred`

## Requirements
- R1: After reset every counter holds 1, weakly not-taken, so every request predicts not-taken, and the history snapshot reads 0.
- R2: The predict index is `pred_addr XOR history`, where `pred_addr` carries branch address bits [11:2] (10 bits) and the history is 10 bits wide. It is read combinationally in the request cycle.
- R3: While `pred_req` is high, `pred_taken` equals bit 1 of the indexed counter (2 and 3 predict taken, 0 and 1 not-taken). While `pred_req` is low, `pred_taken` is 0.
- R4: An update with `upd_taken`=1 raises the counter at its index by one and holds it at 3.
- R5: An update with `upd_taken`=0 lowers the counter at its index by one and holds it at 0.
- R6: The update index is `upd_addr XOR upd_hist`. It is formed from the supplied snapshot and not from the current history, and no other entry changes.
- R7: On each update the history shifts left by one and takes `upd_taken` into bit 0. Without an update the history holds its value. `pred_hist` always shows the current history.
- R8: An update is written at the clock edge that ends its cycle. A prediction of the same entry in that cycle returns the old counter, and the new value shows from the next cycle.
- R9: While `upd_valid` is low, the values on `upd_addr`, `upd_taken` and `upd_hist` change neither the table nor the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pred_req | input | 1 | Prediction request |
| pred_addr | input | 10 | Branch address bits [11:2] of the predicted branch |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | 10 | History snapshot used for this prediction |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_addr | input | 10 | Branch address bits [11:2] of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_hist | input | 10 | Snapshot returned with that branch's prediction |

## Verification
The only view of a counter from the ports is its upper bit. A corrupted counter may therefore stay hidden until that entry is predicted again, and a faulty saturation shows only after a later opposite update takes the counter across the 1/2 boundary. The bench pushes each counter into saturation and then counts back across that boundary to expose this. A wrong history is visible on `pred_hist` in the cycle right after the faulty update. A wrong index computation shows up as a counter moving at an entry that should not have been touched, which the bench finds by probing both the target entry and its address-only neighbour.

// File: rtl/hxp_pkg.sv
`timescale 1ns/1ps
package hxp_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;

  localparam ctr_t CTR_MAX = '1;
  localparam ctr_t CTR_MIN = '0;
  localparam ctr_t CTR_RST = ctr_t'(1);

  // saturating move toward the resolved outcome
  function automatic ctr_t ctr_step(ctr_t c, logic up);
    ctr_t r;
    if (up) r = (c == CTR_MAX) ? c : ctr_t'(c + ctr_t'(1));
    else    r = (c == CTR_MIN) ? c : ctr_t'(c - ctr_t'(1));
    return r;
  endfunction

  function automatic logic ctr_dir(ctr_t c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/hxp_rst_sync.sv
`timescale 1ns/1ps
module hxp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/hxp_hash.sv
`timescale 1ns/1ps
module hxp_hash #(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] addr_bits,
  input  logic [IDX_W-1:0] hist_bits,
  output logic [IDX_W-1:0] idx
);
  genvar b;
  generate
    for (b = 0; b < IDX_W; b++) begin : g_bit
      assign idx[b] = addr_bits[b] ^ hist_bits[b];
    end
  endgenerate
endmodule

// File: rtl/hxp_ghr.sv
`timescale 1ns/1ps
module hxp_ghr #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) hist_d = {hist_q[HIST_W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/hxp_ctr_table.sv
`timescale 1ns/1ps
module hxp_ctr_table
  import hxp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output ctr_t             rd_a_ctr,
  input  logic [IDX_W-1:0] rd_b_idx,
  output ctr_t             rd_b_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_RST;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_ctr;
    end
  end

  assign rd_a_ctr = mem[rd_a_idx];
  assign rd_b_ctr = mem[rd_b_idx];
endmodule

// File: rtl/hist_xor_dir_pred.sv
`timescale 1ns/1ps
module hist_xor_dir_pred
  import hxp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pred_req,
  input  logic [IDX_W-1:0] pred_addr,
  output logic             pred_taken,
  output logic [IDX_W-1:0] pred_hist,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_addr,
  input  logic             upd_taken,
  input  logic [IDX_W-1:0] upd_hist
);
  localparam int HIST_W = IDX_W;

  logic              rst_sync_n;
  logic [HIST_W-1:0] ghr;
  logic [IDX_W-1:0]  pred_idx;
  logic [IDX_W-1:0]  upd_idx;
  ctr_t              pred_ctr;
  ctr_t              upd_ctr_old;
  ctr_t              upd_ctr_new;

  hxp_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  hxp_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist      (ghr)
  );

  hxp_hash #(.IDX_W(IDX_W)) u_pred_hash (
    .addr_bits (pred_addr),
    .hist_bits (ghr),
    .idx       (pred_idx)
  );

  hxp_hash #(.IDX_W(IDX_W)) u_upd_hash (
    .addr_bits (upd_addr),
    .hist_bits (upd_hist),
    .idx       (upd_idx)
  );

  always_comb begin
    upd_ctr_new = ctr_step(upd_ctr_old, upd_taken);
  end

  hxp_ctr_table #(.IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_a_idx (pred_idx),
    .rd_a_ctr (pred_ctr),
    .rd_b_idx (upd_idx),
    .rd_b_ctr (upd_ctr_old),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_ctr   (upd_ctr_new)
  );

  assign pred_taken = pred_req & ctr_dir(pred_ctr);
  assign pred_hist  = ghr;
endmodule

// File: rtl/hxp_checker.sv
`timescale 1ns/1ps
module hxp_checker
  import hxp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pred_req,
  input logic             pred_taken,
  input logic [IDX_W-1:0] pred_hist,
  input logic [IDX_W-1:0] pred_idx,
  input ctr_t             pred_ctr,
  input logic             upd_valid,
  input logic             upd_taken,
  input logic [IDX_W-1:0] upd_idx,
  input ctr_t             upd_ctr_old
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1: history is clear in the first cycle out of reset
  a_r1_hist_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> pred_hist == '0);

  // R3: no request, no taken
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_req |-> !pred_taken);

  // R7: shift on update, hold otherwise
  a_r7_ghr_shift: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> pred_hist == {$past(pred_hist[IDX_W-2:0]), $past(upd_taken)});

  a_r7_ghr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pred_hist));

  // R4: taken update raises the entry, saturating at the top
  a_r4_inc_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(upd_valid && upd_taken) && pred_idx == $past(upd_idx))
    |-> pred_ctr == (($past(upd_ctr_old) == CTR_MAX) ? CTR_MAX
                     : ctr_t'($past(upd_ctr_old) + ctr_t'(1))));

  // R5: not-taken update lowers the entry, saturating at the bottom
  a_r5_dec_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(upd_valid && !upd_taken) && pred_idx == $past(upd_idx))
    |-> pred_ctr == (($past(upd_ctr_old) == CTR_MIN) ? CTR_MIN
                     : ctr_t'($past(upd_ctr_old) - ctr_t'(1))));

  // R9: without an update the entry being read does not move
  a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(upd_valid) && $stable(pred_idx)) |-> $stable(pred_ctr));
endmodule

bind hist_xor_dir_pred hxp_checker #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .pred_req    (pred_req),
  .pred_taken  (pred_taken),
  .pred_hist   (pred_hist),
  .pred_idx    (pred_idx),
  .pred_ctr    (pred_ctr),
  .upd_valid   (upd_valid),
  .upd_taken   (upd_taken),
  .upd_idx     (upd_idx),
  .upd_ctr_old (upd_ctr_old)
);

// File: tb/tb_hist_xor_dir_pred.sv
`timescale 1ns/1ps
module tb_hist_xor_dir_pred;
  localparam int IDX_W = 10;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk;
  logic             rst_n;
  logic             pred_req;
  logic [IDX_W-1:0] pred_addr;
  logic             pred_taken;
  logic [IDX_W-1:0] pred_hist;
  logic             upd_valid;
  logic [IDX_W-1:0] upd_addr;
  logic             upd_taken;
  logic [IDX_W-1:0] upd_hist;

  int total;
  int bad;
  logic [1:0]       m_ctr [DEPTH];
  logic [IDX_W-1:0] m_ghr;

  hist_xor_dir_pred #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .pred_req(pred_req), .pred_addr(pred_addr),
    .pred_taken(pred_taken), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_addr(upd_addr),
    .upd_taken(upd_taken), .upd_hist(upd_hist)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one update cycle, model follows the requirements
  task automatic do_update(input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] h,
                           input logic t);
    logic [IDX_W-1:0] ix;
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_hist = h; upd_taken = t;
    @(posedge clk);
    ix = a ^ h;
    if (t)  m_ctr[ix] = (m_ctr[ix] == 2'd3) ? 2'd3 : m_ctr[ix] + 2'd1;
    else    m_ctr[ix] = (m_ctr[ix] == 2'd0) ? 2'd0 : m_ctr[ix] - 2'd1;
    m_ghr = {m_ghr[IDX_W-2:0], t};
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // predict the entry at a given table index, compare direction and history
  task automatic probe(input logic [IDX_W-1:0] ix, input logic rq, input string tag);
    @(negedge clk);
    pred_req = rq; pred_addr = ix ^ m_ghr;
    #1;
    chk({tag, " dir"}, int'(pred_taken), rq ? int'(m_ctr[ix][1]) : 0);
    chk({tag, " hist"}, int'(pred_hist), int'(m_ghr));
  endtask

  task automatic t_reset();
    probe(10'h000, 1'b1, "R1 entry0");
    probe(10'h005, 1'b1, "R1 entry5");
    probe(10'h3FF, 1'b1, "R1 entryTop");
    chk("R1 hist zero", int'(pred_hist), 0);
  endtask

  task automatic t_sat_high();
    for (int i = 0; i < 5; i++) do_update(10'h015, 10'h000, 1'b1);
    probe(10'h015, 1'b1, "R4 saturated taken");
    do_update(10'h015, 10'h000, 1'b0);
    probe(10'h015, 1'b1, "R4 one back stays taken");
    do_update(10'h015, 10'h000, 1'b0);
    probe(10'h015, 1'b1, "R4 two back not-taken");
    chk("R4 explicit", int'(pred_taken), 0);
  endtask

  task automatic t_sat_low();
    for (int i = 0; i < 4; i++) do_update(10'h2A0, 10'h000, 1'b0);
    do_update(10'h2A0, 10'h000, 1'b1);
    probe(10'h2A0, 1'b1, "R5 one up from floor");
    chk("R5 explicit", int'(pred_taken), 0);
    do_update(10'h2A0, 10'h000, 1'b1);
    probe(10'h2A0, 1'b1, "R5 two up taken");
    chk("R5 explicit taken", int'(pred_taken), 1);
  endtask

  task automatic t_hash();
    do_update(10'h0F0, 10'h00F, 1'b1);
    do_update(10'h0F0, 10'h00F, 1'b1);
    probe(10'h0FF, 1'b1, "R6 hashed entry");
    chk("R6 hashed explicit", int'(pred_taken), 1);
    probe(10'h0F0, 1'b1, "R6 address-only entry");
    chk("R6 untouched explicit", int'(pred_taken), 0);
    probe(10'h015 ^ 10'h2A0, 1'b1, "R2 mixed index");
  endtask

  task automatic t_ghr();
    logic [IDX_W-1:0] h0;
    do_update(10'h111, 10'h000, 1'b1);
    do_update(10'h111, 10'h000, 1'b0);
    do_update(10'h111, 10'h000, 1'b1);
    h0 = m_ghr;
    probe(10'h111, 1'b1, "R7 shifted history");
    chk("R7 low bits", int'(pred_hist[2:0]), 3'b101);
    repeat (3) @(negedge clk);
    #1;
    chk("R7 hold idle", int'(pred_hist), int'(h0));
  endtask

  task automatic t_noreq();
    probe(10'h0FF, 1'b0, "R3 no request");
    probe(10'h0FF, 1'b1, "R3 request");
  endtask

  task automatic t_same_cycle();
    logic [IDX_W-1:0] ix;
    ix = 10'h333;
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = ix; upd_hist = 10'h000; upd_taken = 1'b1;
    pred_req = 1'b1; pred_addr = ix ^ m_ghr;
    #1;
    chk("R8 old value in write cycle", int'(pred_taken), 0);
    @(posedge clk);
    m_ctr[ix] = 2'd2;
    m_ghr = {m_ghr[IDX_W-2:0], 1'b1};
    @(negedge clk);
    upd_valid = 1'b0;
    probe(ix, 1'b1, "R8 new value next cycle");
    chk("R8 explicit", int'(pred_taken), 1);
  endtask

  task automatic t_no_update();
    logic [IDX_W-1:0] h0;
    h0 = m_ghr;
    @(negedge clk);
    upd_valid = 1'b0; upd_addr = 10'h044; upd_hist = 10'h000; upd_taken = 1'b1;
    repeat (4) @(posedge clk);
    probe(10'h044, 1'b1, "R9 entry unchanged");
    chk("R9 explicit", int'(pred_taken), 0);
    chk("R9 history unchanged", int'(pred_hist), int'(h0));
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2'd1;
    m_ghr = '0;
    rst_n = 1'b0;
    pred_req = 1'b0; pred_addr = '0;
    upd_valid = 1'b0; upd_addr = '0; upd_taken = 1'b0; upd_hist = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sat_high();
    t_sat_low();
    t_hash();
    t_ghr();
    t_noreq();
    t_same_cycle();
    t_no_update();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule